// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block keeps the interrupt-related state of a USB host controller's register file. It holds command bits, event status bits, per-source enable bits, a master enable and an interrupt-rate threshold. It drives one level-sensitive interrupt request toward the host bus. Hardware raises status bits with single-cycle event pulses. Software reaches the state through a 32-bit register port with word offsets.

Software can only set command bits. The consuming logic clears them with acknowledge pulses. Status bits are cleared by writing ones to them. Enables are reached through two addresses that read back the same state: a set view and a clear view. The request is raised only for a status bit that is both set and enabled, and only while the master enable is on. The threshold field sets a minimum number of micro-frame ticks between two assertions of the request.

Top module: `hirq_ctrl`

## Requirements
- R1: After reset the status, enables, master enable, command bits and request are all 0, and the threshold field (offset 0x10, bits [7:0]) reads 8.
- R2: A write to the command view (offset 0x00, bits [NCMD-1:0]) sets each bit written 1 and leaves each bit written 0 unchanged. A pulse on `cmd_ack` clears the matching command bit. A write and an acknowledge hitting the same bit in one cycle leave it set.
- R3: Writing 1 to a bit at the enable-set view (offset 0x08) sets that enable. Writing 1 to the same bit at the enable-clear view (offset 0x0C) clears it. Writing 0 to either view changes nothing. Both views read the same value: per-source enables in bits [NEV-1:0] and the master enable in bit 31.
- R4: An event pulse sets its status bit (offset 0x04, bits [NEV-1:0]) whether or not the source is enabled. Writing 1 to a status bit clears it, and writing 0 leaves it.
- R5: If an event pulse and a software clear hit the same status bit in one cycle, the bit ends up set.
- R6: `irq` is 1 one cycle after some status bit and its enable are both 1 while the master enable is 1. It falls one cycle after that condition ends.
- R7: `irq` may only go from 0 to 1 once at least `thr` `uframe_tick` pulses have been seen since its previous rise. The tick counter saturates at 255. The first rise after reset is not held back. A threshold of 0 imposes no limit.
- R8: Reserved bits read 0 and ignore writes. Offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the register access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| evt_pulse | input | NEV | Hardware event pulses, one per source |
| cmd_ack | input | NCMD | Clears matching command bits |
| cmd_bits | output | NCMD | Current command bits |
| uframe_tick | input | 1 | One pulse per micro-frame |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong enable or status bit shows up in the readback of its view on the same cycle, and as a wrong `irq` level one cycle later. A counter error in the threshold logic shows only at the next rise of `irq`: the request comes early or late compared with the tick count the bench has applied. The bench therefore counts ticks exactly across the threshold boundary, one tick at a time. The same-cycle set and clear collisions on command and status bits can only be seen by readback on the cycle after the collision, so the bench reads them there.

// File: rtl/hirq_ctrl.sv
module hirq_ctrl #(
  parameter int NEV     = 6,
  parameter int NCMD    = 4,
  parameter int AW      = 8,
  parameter int TW      = 8,
  parameter int THR_RST = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic [NEV-1:0]  evt_pulse,
  input  logic [NCMD-1:0] cmd_ack,
  output logic [NCMD-1:0] cmd_bits,
  input  logic            uframe_tick,
  output logic            irq
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [NCMD-1:0] cmd_q;
  logic [NEV-1:0]  sts_q, en_q;
  logic            mie_q, irq_q;
  logic [TW-1:0]   thr_q, ucnt_q;

  wire in_range = (addr[AW-1:5] == '0);
  wire [2:0] widx = addr[4:2];
  wire w_cmd = wr_en && in_range && widx == 3'd0;
  wire w_sts = wr_en && in_range && widx == 3'd1;
  wire w_ens = wr_en && in_range && widx == 3'd2;
  wire w_enc = wr_en && in_range && widx == 3'd3;
  wire w_thr = wr_en && in_range && widx == 3'd4;

  wire pending = mie_q && |(sts_q & en_q);
  wire gap_ok  = ucnt_q >= thr_q;
  wire rise    = pending && !irq_q && gap_ok;

  wire [31:0] en_view = {mie_q, {(31-NEV){1'b0}}, en_q};

  always_comb begin
    rd_data = '0;
    if (in_range)
      case (widx)
        3'd0: rd_data = {{(32-NCMD){1'b0}}, cmd_q};
        3'd1: rd_data = {{(32-NEV){1'b0}}, sts_q};
        3'd2, 3'd3: rd_data = en_view;
        3'd4: rd_data = {{(32-TW){1'b0}}, thr_q};
        default: rd_data = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      sts_q  <= '0;
      en_q   <= '0;
      mie_q  <= 1'b0;
      thr_q  <= TW'(THR_RST);
      ucnt_q <= CNT_MAX;
      irq_q  <= 1'b0;
    end else begin
      cmd_q <= (cmd_q & ~cmd_ack) | (w_cmd ? wr_data[NCMD-1:0] : '0);
      sts_q <= (sts_q & ~(w_sts ? wr_data[NEV-1:0] : '0)) | evt_pulse;
      if (w_ens) begin
        en_q  <= en_q | wr_data[NEV-1:0];
        mie_q <= mie_q | wr_data[31];
      end else if (w_enc) begin
        en_q  <= en_q & ~wr_data[NEV-1:0];
        mie_q <= mie_q & ~wr_data[31];
      end
      if (w_thr) thr_q <= wr_data[TW-1:0];
      if (rise) ucnt_q <= '0;
      else if (uframe_tick && ucnt_q != CNT_MAX) ucnt_q <= ucnt_q + 1'b1;
      irq_q <= pending && (irq_q || gap_ok);
    end
  end

  assign cmd_bits = cmd_q;
  assign irq      = irq_q;
endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk #(
  parameter int NEV  = 6,
  parameter int NCMD = 4,
  parameter int TW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NEV-1:0]  evt_pulse,
  input logic [NCMD-1:0] cmd_ack,
  input logic [NCMD-1:0] cmd_bits,
  input logic [NEV-1:0]  sts_q,
  input logic [NEV-1:0]  en_q,
  input logic            mie_q,
  input logic [TW-1:0]   thr_q,
  input logic            uframe_tick,
  input logic            irq
);
  logic [TW-1:0] gap;
  logic          irq_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '1;
      irq_d <= 1'b0;
    end else begin
      irq_d <= irq;
      if (irq && !irq_d) gap <= uframe_tick ? TW'(1) : '0;
      else if (uframe_tick && gap != '1) gap <= gap + 1'b1;
    end
  end

  AST_CMD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_bits & $past(cmd_bits & ~cmd_ack)) == $past(cmd_bits & ~cmd_ack))); // R2
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((sts_q & $past(evt_pulse)) == $past(evt_pulse))); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mie_q && ((sts_q & en_q) != '0))); // R6
  AST_THR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(gap) >= $past(thr_q))); // R7
endmodule

bind hirq_ctrl hirq_ctrl_chk #(.NEV(NEV), .NCMD(NCMD), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cmd_ack(cmd_ack),
  .cmd_bits(cmd_bits), .sts_q(sts_q), .en_q(en_q), .mie_q(mie_q),
  .thr_q(thr_q), .uframe_tick(uframe_tick), .irq(irq));

// File: tb/hirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module hirq_ctrl_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, uframe_tick = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [5:0]  evt_pulse = '0;
  logic [3:0]  cmd_ack = '0, cmd_bits;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hirq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
    .cmd_ack(cmd_ack), .cmd_bits(cmd_bits), .uframe_tick(uframe_tick), .irq(irq));

  // {req, addr, wdata, expected readback of addr}
  localparam logic [79:0] VEC [10] = '{
    {8'd2, 8'h00, 32'h0000_0005, 32'h0000_0005}, // R2 set
    {8'd8, 8'h00, 32'hFFFF_FFF2, 32'h0000_0007}, // R8 reserved, R2 zero keeps
    {8'd3, 8'h08, 32'h8000_0003, 32'h8000_0003}, // R3 set view
    {8'd3, 8'h0C, 32'h0000_0001, 32'h8000_0002}, // R3 clear view
    {8'd8, 8'h08, 32'h7FFF_FFC0, 32'h8000_0002}, // R8 reserved enable bits
    {8'd3, 8'h0C, 32'h8000_0000, 32'h0000_0002}, // R3 master clear
    {8'd8, 8'h10, 32'h0000_0103, 32'h0000_0003}, // R8 threshold width
    {8'd7, 8'h10, 32'h0000_0000, 32'h0000_0000}, // R7 threshold 0
    {8'd8, 8'h14, 32'hFFFF_FFFF, 32'h0000_0000}, // R8 unmapped
    {8'd4, 8'h04, 32'hFFFF_FFFF, 32'h0000_0000}  // R4 clear of empty status
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1 d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); uframe_tick = 1;
    @(negedge clk); uframe_tick = 0;
  endtask

  task automatic evt(input logic [5:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic reset_state_checks();
    logic [31:0] v;
    rd(8'h04, v); chk("R1 status", v, 0);
    rd(8'h08, v); chk("R1 enable", v, 0);
    rd(8'h10, v); chk("R1 threshold", v, 32'd8);
    chk("R1 cmd", {28'd0, cmd_bits}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reset_state_checks();

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk($sformatf("R%0d vec%0d", VEC[i][79:72], i), v, VEC[i][31:0]);
    end

    // R2 acknowledge clears, and set beats acknowledge
    @(negedge clk); cmd_ack = 4'b0001;
    @(negedge clk); cmd_ack = '0;
    chk("R2 ack", {28'd0, cmd_bits}, 32'h6);
    @(negedge clk); wr_en = 1; addr = 8'h00; wr_data = 32'h2; cmd_ack = 4'b0010;
    @(negedge clk); wr_en = 0; cmd_ack = '0;
    chk("R2 set wins", {28'd0, cmd_bits}, 32'h6);

    // R4 disabled source still records; master off keeps irq low
    evt(6'b001000);
    rd(8'h04, v); chk("R4 record", v, 32'h8);
    chk("R6 no irq", {31'd0, irq}, 0);
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, v); chk("R4 zero keeps", v, 32'h8);
    wr(8'h04, 32'h0000_0008);
    rd(8'h04, v); chk("R4 w1c", v, 0);

    // R5 event and clear on same bit in one cycle
    evt(6'b000100);
    @(negedge clk); wr_en = 1; addr = 8'h04; wr_data = 32'h5; evt_pulse = 6'b000001;
    @(negedge clk); wr_en = 0; evt_pulse = '0;
    rd(8'h04, v); chk("R5 set wins", v, 32'h1);

    // R6 irq timing, threshold 0
    wr(8'h08, 32'h8000_0001);
    chk("R6 irq latency", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R6 irq high", {31'd0, irq}, 1);
    wr(8'h0C, 32'h8000_0000);
    chk("R6 still high", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R6 irq falls", {31'd0, irq}, 0);

    // R7 threshold of 3 ticks since last rise
    wr(8'h10, 32'h3);
    wr(8'h08, 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk("R7 held no ticks", {31'd0, irq}, 0);
    tick(); tick();
    @(negedge clk);
    chk("R7 held two ticks", {31'd0, irq}, 0);
    tick();
    chk("R7 third tick latency", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R7 released", {31'd0, irq}, 1);

    // R1 again after reset, R7 first rise not held back with threshold 8
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    reset_state_checks();
    evt(6'b000010);
    wr(8'h08, 32'h8000_0002);
    @(negedge clk);
    chk("R7 first rise immediate", {31'd0, irq}, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule